// File: doc/BRIEF.md
# Escalating Watchdog Timer

A per-core watchdog built around a prescaled down-counter. Software arms it with a configuration write that carries a 16-bit reload length and a 2-bit mode. The length forms the upper bits of a wider counter whose low bits reload as zero. A prescaler divides the input clock by a build-time divisor, and the counter steps once per prescaler tick. A period is therefore `length * 2^FRAC_W` ticks, or `length * 2^FRAC_W * PRESCALE` clock cycles.

Each time a period runs out without a poke, the block climbs one stage up a fixed ladder: first an interrupt, then a non-maskable interrupt, then a one-cycle soft-reset request. After the request it parks in a terminal stage. Every expiry reloads the counter, so each stage lasts exactly one period. A poke restarts the period and drops the stage back to idle. The mode sets how far the ladder may climb, and mode 0 or a zero length disables the block. The live count and the current stage are always visible for software to poll.

Top module: `esc_wdog`

## Requirements
- R1: After reset the block is disabled. `count_o` is 0, `stage_o` is 0 (idle), and `irq_o`, `nmi_o` and `soft_rst_o` are low.
- R2: A configuration write with a nonzero mode and a nonzero length loads `count_o` with `{len, FRAC_W zero bits}` on the next clock edge. From then on the count drops by one every `PRESCALE` clock cycles and holds between those steps.
- R3: `stage_o` uses the encoding 0 = idle, 1 = interrupt, 2 = NMI, 3 = terminal. Without a restart, it only stays where it is or rises by exactly one.
- R4: In mode 3:
  - the first expiry, `len * 2^FRAC_W * PRESCALE` cycles after the load, sets stage 1 and raises `irq_o`;
  - the second expiry sets stage 2 and raises `nmi_o`, while `irq_o` stays high;
  - on the cycle before an expiry the count reads 1.
- R5: The third expiry in mode 3 sets stage 3 and pulses `soft_rst_o` high for exactly one cycle. The block then holds stage 3 with the count frozen until it is poked or reconfigured.
- R6: Mode 1 caps the stage at 1 and mode 2 caps it at 2. While capped, the counter keeps counting down and reloading.
- R7: When enabled, a poke (`poke_i` high for a cycle) reloads the count from the stored length and returns the stage to idle, which drops `irq_o` and `nmi_o`.
- R8:
  - A configuration write always clears the stage.
  - A write with mode 0 or length 0 disables the block: the count reads 0 and all three outputs stay low.
  - A poke while disabled has no effect.
- R9: Priorities within one cycle:
  - a configuration write wins over a poke, so the new length is loaded;
  - a poke wins over an expiry, so the stage stays idle and the count reloads.
- R10: While enabled, `count_o` lies between 1 and `{len, FRAC_W zero bits}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_len_i | input | LEN_W | Reload length (upper counter bits) |
| cfg_mode_i | input | 2 | 0 off, 1 interrupt only, 2 up to NMI, 3 full ladder |
| poke_i | input | 1 | Service strobe |
| count_o | output | LEN_W+FRAC_W | Live down-counter value |
| stage_o | output | 2 | Current escalation stage |
| irq_o | output | 1 | Interrupt, level; rises on entering stage 1 |
| nmi_o | output | 1 | Non-maskable interrupt, high from stage 2 |
| soft_rst_o | output | 1 | One-cycle soft-reset request |

## Verification
Two pairs of events can fall in the same cycle:
- A poke can coincide with a counter expiry. The bench raises `poke_i` across exactly the edge on which the period ends, after counting `len * 2^FRAC_W * PRESCALE - 1` cycles from the load. It then expects stage 0 and a freshly reloaded count instead of an interrupt.
- A configuration write can coincide with a poke. The bench drives both strobes on one edge and expects the new length in the count.

Both outcomes are judged one cycle later at the ports. A further full period is then timed to confirm that the prescaler restarted from zero.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IRQ  = 2'd1,
    ST_NMI  = 2'd2,
    ST_TERM = 2'd3
  } stage_e;

  // highest stage a mode may reach
  function automatic stage_e mode_limit(input logic [1:0] mode);
    case (mode)
      2'd1:    return ST_IRQ;
      2'd2:    return ST_NMI;
      2'd3:    return ST_TERM;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/esc_wdog_prescaler.sv
module esc_wdog_prescaler #(
  parameter int unsigned PRESCALE = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (run_i)   pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  assign tick_o = run_i && !clr_i && (pre_q == LAST);

  // R2: ticks never come back to back
  p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/esc_wdog_counter.sv
module esc_wdog_counter #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned CW    = LEN_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_len_i,
  input  logic             tick_i,
  output logic [CW-1:0]    count_o,
  output logic             expire_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload;

  assign reload   = {load_len_i, {FRAC_W{1'b0}}};
  assign expire_o = tick_i && (cnt_q <= CW'(1));
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (load_i)   cnt_q <= reload;
    else if (tick_i)   cnt_q <= expire_o ? reload : cnt_q - 1'b1;
  end

  // R2: one step down per tick
  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !load_i && cnt_q > CW'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R2: hold between ticks
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i && !load_i) |=> $stable(cnt_q));

  // R4: expiry lands on a full reload
  p_expire_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !clr_i) |=> cnt_q[FRAC_W-1:0] == '0);

endmodule

// File: rtl/esc_wdog_stage.sv
module esc_wdog_stage
  import esc_wdog_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   restart_i,
  input  logic   expire_i,
  input  stage_e limit_i,
  output stage_e stage_o,
  output logic   soft_rst_o
);
  stage_e stage_q;
  logic   pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else if (restart_i) begin
      stage_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (expire_i && (stage_q < limit_i)) begin
        stage_q <= stage_e'(stage_q + 2'd1);
        pulse_q <= (stage_q == ST_NMI);
      end
    end
  end

  assign stage_o    = stage_q;
  assign soft_rst_o = pulse_q;

  // R3: single-step climb
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> (stage_q == $past(stage_q)) || (stage_q == stage_e'($past(stage_q) + 2'd1)));

  // R6: never above the mode cap
  p_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> stage_q <= $past(limit_i) || stage_q == $past(stage_q));

  // R5: reset request lasts one cycle
  p_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  // R5: request only on entry to terminal
  p_pulse_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_o) |-> stage_q == ST_TERM && $past(stage_q) == ST_NMI);

  // R7: restart returns to idle
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> stage_q == ST_IDLE && !soft_rst_o);

endmodule

// File: rtl/esc_wdog.sv
module esc_wdog
  import esc_wdog_pkg::*;
#(
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned PRESCALE = 256,
  localparam int unsigned CW      = LEN_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             poke_i,
  output logic [CW-1:0]    count_o,
  output logic [1:0]       stage_o,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             soft_rst_o
);
  logic [LEN_W-1:0] len_q;
  logic [1:0]       mode_q;
  logic             enable, new_en, poke_eff, restart;
  logic             cnt_clr, cnt_load, run, tick, expire;
  logic [LEN_W-1:0] load_len;
  stage_e           stage, limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      mode_q <= 2'd0;
    end else if (cfg_we_i) begin
      len_q  <= cfg_len_i;
      mode_q <= cfg_mode_i;
    end
  end

  assign enable   = (|len_q) && (|mode_q);
  assign new_en   = (|cfg_len_i) && (|cfg_mode_i);
  // config write beats poke; poke beats expiry
  assign poke_eff = poke_i && enable && !cfg_we_i;
  assign restart  = cfg_we_i || poke_eff;
  assign cnt_clr  = cfg_we_i && !new_en;
  assign cnt_load = (cfg_we_i && new_en) || poke_eff;
  assign load_len = cfg_we_i ? cfg_len_i : len_q;
  assign run      = enable && (stage != ST_TERM);
  assign limit    = mode_limit(mode_q);

  esc_wdog_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (restart),
    .tick_o (tick)
  );

  esc_wdog_counter #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cnt_clr),
    .load_i     (cnt_load),
    .load_len_i (load_len),
    .tick_i     (tick),
    .count_o    (count_o),
    .expire_o   (expire)
  );

  esc_wdog_stage u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .expire_i   (expire),
    .limit_i    (limit),
    .stage_o    (stage),
    .soft_rst_o (soft_rst_o)
  );

  assign stage_o = stage;
  assign irq_o   = (stage != ST_IDLE);
  assign nmi_o   = (stage == ST_NMI) || (stage == ST_TERM);

  // R8: disabled block is silent
  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable |-> count_o == '0 && !irq_o && !nmi_o && !soft_rst_o);

  // R10: live count stays in range
  p_count_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable |-> count_o != '0 && count_o <= {len_q, {FRAC_W{1'b0}}});

  // R4: interrupt rises only from idle on an expiry
  p_irq_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(expire) && $past(stage) == ST_IDLE);

  // R9: config beats poke
  p_cfg_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && poke_i && new_en) |=> count_o == {$past(cfg_len_i), {FRAC_W{1'b0}}});

  // R9: poke beats expiry
  p_poke_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poke_i && enable && expire) |=> stage_o == 2'd0 && !irq_o);

endmodule

// File: tb/esc_wdog_test.sv
module esc_wdog_test;
  localparam int LEN_W = 16;
  localparam int FRAC_W = 2;
  localparam int PRESCALE = 4;
  localparam int CW = LEN_W + FRAC_W;
  localparam int TPL = PRESCALE * (1 << FRAC_W); // cycles per unit of length

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, poke = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [1:0] cfg_mode = 2'd0;
  logic [CW-1:0] count;
  logic [1:0] stage;
  logic irq, nmi, srst;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  esc_wdog #(.LEN_W(LEN_W), .FRAC_W(FRAC_W), .PRESCALE(PRESCALE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_len_i(cfg_len),
    .cfg_mode_i(cfg_mode), .poke_i(poke), .count_o(count), .stage_o(stage),
    .irq_o(irq), .nmi_o(nmi), .soft_rst_o(srst));

  typedef struct packed {
    logic [15:0] len;
    logic [1:0]  mode;
    logic [3:0]  nexp;
    logic [1:0]  st;
    logic        irq;
    logic        nmi;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{16'd1, 2'd3, 4'd1, 2'd1, 1'b1, 1'b0},
    '{16'd1, 2'd3, 4'd2, 2'd2, 1'b1, 1'b1},
    '{16'd2, 2'd3, 4'd3, 2'd3, 1'b1, 1'b1},
    '{16'd2, 2'd1, 4'd3, 2'd1, 1'b1, 1'b0},
    '{16'd1, 2'd2, 4'd4, 2'd2, 1'b1, 1'b1},
    '{16'd3, 2'd3, 4'd0, 2'd0, 1'b0, 1'b0},
    '{16'd1, 2'd0, 4'd2, 2'd0, 1'b0, 1'b0},
    '{16'd0, 2'd3, 4'd2, 2'd0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [15:0] len, input logic [1:0] mode);
    cfg_len = len; cfg_mode = mode; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_poke();
    poke = 1'b1;
    @(negedge clk);
    poke = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 stage", stage, 0);
    check("R1 outs", {irq, nmi, srst}, 0);

    // table: R4 R5 R6 R8
    foreach (TBL[i]) begin
      int en;
      en = (TBL[i].len != 0) && (TBL[i].mode != 0);
      write_cfg(TBL[i].len, TBL[i].mode);
      step(int'(TBL[i].nexp) * TPL * int'(TBL[i].len));
      check("R4/R6 stage", stage, TBL[i].st);
      check("R4 irq", irq, TBL[i].irq);
      check("R4 nmi", nmi, TBL[i].nmi);
      check("R8/R10 count", count, en ? 4 * TBL[i].len : 0);
    end

    // R2 prescaled countdown
    write_cfg(16'd2, 2'd3);
    check("R2 load", count, 8);
    step(4);  check("R2 step", count, 7);
    step(3);  check("R2 hold", count, 7);
    step(1);  check("R2 step2", count, 6);

    // R4 boundary before first expiry
    write_cfg(16'd1, 2'd3);
    step(TPL - 1);
    check("R4 pre count", count, 1);
    check("R4 pre irq", irq, 0);
    step(1);
    check("R4 irq rise", {stage, irq}, {2'd1, 1'b1});

    // R5 reset pulse and terminal hold
    write_cfg(16'd1, 2'd3);
    step(3 * TPL);
    check("R5 pulse", {stage, srst}, {2'd3, 1'b1});
    step(1);
    check("R5 pulse end", srst, 0);
    step(50);
    check("R5 terminal", {stage, count}, {2'd3, 18'd4});

    // R7 poke from terminal
    do_poke();
    check("R7 poke", {stage, irq, nmi}, 0);
    check("R7 reload", count, 4);

    // R9 poke on the expiry edge
    write_cfg(16'd1, 2'd3);
    step(TPL - 1);
    do_poke();
    check("R9 poke wins stage", stage, 0);
    check("R9 poke wins count", count, 4);
    step(TPL - 1);
    check("R9 restart count", {stage, count}, {2'd0, 18'd1});
    step(1);
    check("R9 restart expiry", stage, 1);

    // R9 config beats poke
    cfg_len = 16'd3; cfg_mode = 2'd1; cfg_we = 1'b1; poke = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; poke = 1'b0;
    check("R9 cfg wins", {stage, count}, {2'd0, 18'd12});

    // R6 capped mode keeps counting
    write_cfg(16'd2, 2'd1);
    step(3 * 2 * TPL + 4);
    check("R6 capped", {stage, count}, {2'd1, 18'd7});

    // R8 reconfig clears stage
    write_cfg(16'd1, 2'd3);
    step(2 * TPL);
    write_cfg(16'd5, 2'd3);
    check("R8 reconfig", {stage, irq, nmi, count}, {2'd0, 1'b0, 1'b0, 18'd20});

    // R8 disabled ignores poke
    write_cfg(16'd5, 2'd0);
    do_poke();
    check("R8 poke ignored", {stage, count}, 0);
    step(200);
    check("R8 silent", {irq, nmi, srst, count}, 0);

    // R3 single steps
    write_cfg(16'd1, 2'd3);
    step(TPL);
    check("R3 step1", stage, 1);
    step(TPL);
    check("R3 step2", stage, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule